// File: doc/BRIEF.md
# Threshold-Driven Transfer Buffer with DMA Requests

This block is the data staging buffer of a card host controller. It holds up to 32 sixteen-bit words in a circular store, addressed by a head pointer and a fill count. One port pushes words in and one port pops words out. In the transmit direction the bus pushes and the card engine pops. In the receive direction the card engine pushes and the bus pops. The surrounding controller steers the two ports and supplies the current direction and a transfer-active level.

A 16-bit configuration word sets two fill thresholds and two DMA enables. When a threshold is crossed in the active direction, the block either raises a level DMA request for that direction or, when DMA is off for that direction, pulses a set strobe for a CPU ready bit. The ready bits themselves live in the controller's interrupt status register. In every cycle that follows a push, a pop, a configuration write or a synchronous clear, the block pulses either a set strobe or a clear strobe for each of the two ready bits. DMA and CPU signalling never overlap for one direction. Both are suppressed while no transfer is active and the buffer is empty.

Top module: `dma_thresh_fifo`

## Requirements
- R1: After reset the fill level is 0, empty is 1, full is 0, both DMA requests and all four strobes are 0, and the configuration reads back 0x1F00. In that word the almost-full threshold is 31 (bits 12:8), the almost-empty threshold is 0 (bits 4:0), and the receive-DMA enable (bit 15) and transmit-DMA enable (bit 7) are both 0.
- R2: Words leave in the order they were pushed. The store is circular: the head pointer wraps modulo 32, and a sequence that runs past the last slot keeps its order.
- R3: A push while 32 words are held is discarded. The fill level stays 32, no stored word changes, and the push counts as no event.
- R4: A pop while the buffer is empty leaves the fill level at 0 and the head pointer unchanged. The read data keeps showing the word at the head, and the pop counts as no event.
- R5: When the direction input is 1 (receive) and the fill count is greater than the almost-full threshold, rx_dreq is 1 if the receive-DMA enable (bit 15) is set. At a count equal to the threshold it is 0.
- R6: When the receive threshold condition holds with receive DMA off, an event cycle yields an rx_rdy_set pulse and rx_dreq stays 0. When the condition does not hold, an event cycle yields an rx_rdy_clr pulse.
- R7: When the direction input is 0 (transmit) and the fill count is less than the almost-empty threshold, tx_dreq is 1 if the transmit-DMA enable (bit 7) is set. At a count equal to the threshold it is 0.
- R8: When the transmit threshold condition holds with transmit DMA off, an event cycle yields a tx_rdy_set pulse and tx_dreq stays 0. Otherwise an event cycle yields a tx_rdy_clr pulse.
- R9: The direction gates each side. In receive direction tx_dreq and tx_rdy_set stay 0, and in transmit direction rx_dreq and rx_rdy_set stay 0.
- R10: While xfer_active is 0 and the buffer is empty, both DMA requests are 0, and an event cycle pulses both clear strobes and neither set strobe.
- R11: A configuration write that sets a DMA enable yields the clear strobe of that direction's ready bit in the following cycle, never its set strobe.
- R12: Strobes appear only in the cycle after a push, a pop, a configuration write or a clear. They last one cycle, and set and clear for one bit are never both 1.
- R13: The synchronous clear empties the buffer and returns the head pointer to slot 0. It takes priority over a push or pop in the same cycle.
- R14: The DMA requests are levels re-evaluated every cycle, so a change of xfer_active or direction alone moves them one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of head pointer and fill count |
| xfer_active | input | 1 | A data transfer is in progress |
| dir_rx | input | 1 | 1 = receive (card to bus), 0 = transmit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Current configuration word |
| wr_en | input | 1 | Push request |
| wr_data | input | 16 | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 16 | Word at the head pointer |
| fill_level | output | 6 | Number of words held |
| full | output | 1 | 32 words held |
| empty | output | 1 | No word held |
| rx_dreq | output | 1 | Receive DMA request, level |
| tx_dreq | output | 1 | Transmit DMA request, level |
| rx_rdy_set | output | 1 | Pulse: set receive-ready status bit |
| rx_rdy_clr | output | 1 | Pulse: clear receive-ready status bit |
| tx_rdy_set | output | 1 | Pulse: set transmit-ready status bit |
| tx_rdy_clr | output | 1 | Pulse: clear transmit-ready status bit |

## Verification
Every output is a register or decodes registers, so every result of a push, pop, clear or configuration write is due exactly one clock edge after the edge that samples it. The strobes are due only in that one cycle. The bench drives each stimulus on a falling edge, holds it across one rising edge, and reads the outputs at the next falling edge, one cycle after the stimulus. There it checks the strobe pulses and the read data at the new head. An extra idle cycle then confirms that the strobes have fallen, and a change of xfer_active alone shows its effect on the requests after the same one-cycle delay.

// File: rtl/dma_thresh_fifo_pkg.sv
package dma_thresh_fifo_pkg;
  localparam int CFG_W     = 16;
  localparam int LVL_W     = 5;
  localparam int RXDMA_BIT = 15;
  localparam int AF_LSB    = 8;
  localparam int TXDMA_BIT = 7;
  localparam int AE_LSB    = 0;

  typedef struct packed {
    logic             rx_dma;
    logic [LVL_W-1:0] af_lvl;
    logic             tx_dma;
    logic [LVL_W-1:0] ae_lvl;
  } buf_cfg_t;

  localparam buf_cfg_t CFG_RST = '{rx_dma: 1'b0, af_lvl: '1, tx_dma: 1'b0, ae_lvl: '0};
endpackage

// File: rtl/dma_thresh_fifo_store.sv
module dma_thresh_fifo_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nx,
  output logic             push_ok,
  output logic             pop_ok
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head_q, head_nx, wr_idx;
  logic [CNT_W-1:0] cnt_q;

  assign push_ok = wr_en & ~clr & (cnt_q != CNT_W'(DEPTH));
  assign pop_ok  = rd_en & ~clr & (cnt_q != '0);
  assign wr_idx  = head_q + cnt_q[PTR_W-1:0];

  always_comb begin
    head_nx  = head_q;
    count_nx = cnt_q;
    if (clr) begin
      head_nx  = '0;
      count_nx = '0;
    end else begin
      if (pop_ok) head_nx = head_q + PTR_W'(1);
      case ({push_ok, pop_ok})
        2'b10:   count_nx = cnt_q + CNT_W'(1);
        2'b01:   count_nx = cnt_q - CNT_W'(1);
        default: count_nx = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_nx;
      cnt_q  <= count_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[head_q];
  assign count   = cnt_q;
endmodule

// File: rtl/dma_thresh_fifo_cfg.sv
module dma_thresh_fifo_cfg
  import dma_thresh_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output buf_cfg_t         cfg_q,
  output buf_cfg_t         cfg_nx,
  output logic [CFG_W-1:0] cfg_rdata
);
  buf_cfg_t wr_cfg;
  logic     unused_cfg_bits;

  assign wr_cfg.rx_dma = cfg_wdata[RXDMA_BIT];
  assign wr_cfg.af_lvl = cfg_wdata[AF_LSB +: LVL_W];
  assign wr_cfg.tx_dma = cfg_wdata[TXDMA_BIT];
  assign wr_cfg.ae_lvl = cfg_wdata[AE_LSB +: LVL_W];
  assign unused_cfg_bits = ^{cfg_wdata[14:13], cfg_wdata[6:5]};

  always_comb begin
    cfg_nx = cfg_q;
    if (cfg_we) cfg_nx = wr_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_nx;
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[RXDMA_BIT]       = cfg_q.rx_dma;
    cfg_rdata[AF_LSB +: LVL_W] = cfg_q.af_lvl;
    cfg_rdata[TXDMA_BIT]       = cfg_q.tx_dma;
    cfg_rdata[AE_LSB +: LVL_W] = cfg_q.ae_lvl;
  end
endmodule

// File: rtl/dma_thresh_fifo_eval.sv
module dma_thresh_fifo_eval
  import dma_thresh_fifo_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_nx,
  input  buf_cfg_t         cfg_nx,
  input  logic             dir_rx,
  input  logic             xfer_active,
  input  logic             evt,
  output logic [1:0]       dreq_q,
  output logic [1:0]       set_q,
  output logic [1:0]       clr_q
);
  localparam int N_LANE = 2;

  logic             live;
  logic [1:0]       dreq_nx, set_nx, clr_nx;

  assign live = xfer_active | (count_nx != '0);

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    logic hit, use_dma;
    assign hit     = (g == 0) ? (dir_rx  & (count_nx > CNT_W'(cfg_nx.af_lvl)))
                              : (!dir_rx & (count_nx < CNT_W'(cfg_nx.ae_lvl)));
    assign use_dma = (g == 0) ? cfg_nx.rx_dma : cfg_nx.tx_dma;
    assign dreq_nx[g] = live & hit & use_dma;
    assign set_nx[g]  = evt & live & hit & ~use_dma;
    assign clr_nx[g]  = evt & ~set_nx[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq_q <= '0;
      set_q  <= '0;
      clr_q  <= '0;
    end else begin
      dreq_q <= dreq_nx;
      set_q  <= set_nx;
      clr_q  <= clr_nx;
    end
  end
endmodule

// File: rtl/dma_thresh_fifo.sv
module dma_thresh_fifo
  import dma_thresh_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             xfer_active,
  input  logic             dir_rx,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] fill_level,
  output logic             full,
  output logic             empty,
  output logic             rx_dreq,
  output logic             tx_dreq,
  output logic             rx_rdy_set,
  output logic             rx_rdy_clr,
  output logic             tx_rdy_set,
  output logic             tx_rdy_clr
);
  logic [CNT_W-1:0] count_nx;
  logic             push_ok, pop_ok, evt;
  buf_cfg_t         cfg_q, cfg_nx;
  logic [1:0]       dreq_q, set_q, clr_q;
  logic             unused_cfg_q;

  dma_thresh_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .count(fill_level), .count_nx(count_nx), .push_ok(push_ok), .pop_ok(pop_ok)
  );

  dma_thresh_fifo_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .cfg_nx(cfg_nx), .cfg_rdata(cfg_rdata)
  );

  assign evt = push_ok | pop_ok | cfg_we | clr;
  assign unused_cfg_q = ^cfg_q;

  dma_thresh_fifo_eval #(.CNT_W(CNT_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .count_nx(count_nx), .cfg_nx(cfg_nx),
    .dir_rx(dir_rx), .xfer_active(xfer_active), .evt(evt),
    .dreq_q(dreq_q), .set_q(set_q), .clr_q(clr_q)
  );

  assign full       = (fill_level == CNT_W'(DEPTH));
  assign empty      = (fill_level == '0);
  assign rx_dreq    = dreq_q[0];
  assign tx_dreq    = dreq_q[1];
  assign rx_rdy_set = set_q[0];
  assign rx_rdy_clr = clr_q[0];
  assign tx_rdy_set = set_q[1];
  assign tx_rdy_clr = clr_q[1];
endmodule

// File: rtl/dma_thresh_fifo_chk.sv
module dma_thresh_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             cfg_we,
  input logic [15:0]      cfg_wdata,
  input logic [15:0]      cfg_rdata,
  input logic             wr_en,
  input logic             rd_en,
  input logic [CNT_W-1:0] fill_level,
  input logic             full,
  input logic             empty,
  input logic             rx_dreq,
  input logic             tx_dreq,
  input logic             rx_rdy_set,
  input logic             rx_rdy_clr,
  input logic             tx_rdy_set,
  input logic             tx_rdy_clr
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en && !clr |=> fill_level == CNT_W'(DEPTH));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en && !wr_en && !clr |=> fill_level == '0);

  a_r5_rx_dreq_needs_dma: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dreq |-> cfg_rdata[15]);

  a_r7_tx_dreq_needs_dma: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq |-> cfg_rdata[7]);

  a_r11_rx_dma_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[15] |=> !rx_rdy_set);

  a_r11_tx_dma_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[7] |=> !tx_rdy_set);

  a_r12_strobe_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rdy_set || rx_rdy_clr || tx_rdy_set || tx_rdy_clr)
      |-> $past(wr_en || rd_en || cfg_we || clr));

  a_r12_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_rdy_set && rx_rdy_clr) && !(tx_rdy_set && tx_rdy_clr));
endmodule

bind dma_thresh_fifo dma_thresh_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .wr_en(wr_en), .rd_en(rd_en), .fill_level(fill_level),
  .full(full), .empty(empty), .rx_dreq(rx_dreq), .tx_dreq(tx_dreq),
  .rx_rdy_set(rx_rdy_set), .rx_rdy_clr(rx_rdy_clr),
  .tx_rdy_set(tx_rdy_set), .tx_rdy_clr(tx_rdy_clr)
);

// File: tb/sim_dma_thresh_fifo.sv
`timescale 1ns/1ps
module sim_dma_thresh_fifo;
  logic clk = 1'b0;
  logic rst_n, clr, xfer_active, dir_rx, cfg_we, wr_en, rd_en;
  logic [15:0] cfg_wdata, cfg_rdata, wr_data, rd_data;
  logic [5:0]  fill_level;
  logic full, empty, rx_dreq, tx_dreq, rx_rdy_set, rx_rdy_clr, tx_rdy_set, tx_rdy_clr;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_thresh_fifo u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .xfer_active(xfer_active), .dir_rx(dir_rx),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .fill_level(fill_level), .full(full), .empty(empty),
    .rx_dreq(rx_dreq), .tx_dreq(tx_dreq), .rx_rdy_set(rx_rdy_set), .rx_rdy_clr(rx_rdy_clr),
    .tx_rdy_set(tx_rdy_set), .tx_rdy_clr(tx_rdy_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic cfg_wr(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [15:0] exp);
    chk(req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic sync_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 fill", fill_level, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 cfg", cfg_rdata, 16'h1F00);
    chk("R1 dreq", {rx_dreq, tx_dreq}, 0);
    chk("R1 strobes", {rx_rdy_set, rx_rdy_clr, tx_rdy_set, tx_rdy_clr}, 0);
  endtask

  task automatic t_order_wrap();
    sync_clear();
    for (int i = 0; i < 20; i++) push(16'(i * 3 + 1));
    for (int i = 0; i < 10; i++) pop_chk("R2 order", 16'(i * 3 + 1));
    for (int i = 20; i < 40; i++) push(16'(i * 3 + 1));
    chk("R2 fill", fill_level, 30);
    for (int i = 10; i < 40; i++) pop_chk("R2 wrap order", 16'(i * 3 + 1));
    chk("R2 empty", empty, 1);
  endtask

  task automatic t_overflow();
    sync_clear();
    for (int i = 0; i < 32; i++) push(16'hA000 + 16'(i));
    chk("R3 full", full, 1);
    push(16'hDEAD);
    chk("R3 fill held", fill_level, 32);
    chk("R3 no strobe", {rx_rdy_set, rx_rdy_clr, tx_rdy_set, tx_rdy_clr}, 0);
    for (int i = 0; i < 32; i++) pop_chk("R3 content", 16'hA000 + 16'(i));
    chk("R3 drained", empty, 1);
  endtask

  task automatic t_empty_read();
    chk("R4 head shown", rd_data, 16'hA000);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R4 fill", fill_level, 0);
    chk("R4 head kept", rd_data, 16'hA000);
    chk("R4 no event", {rx_rdy_set, rx_rdy_clr, tx_rdy_set, tx_rdy_clr}, 0);
  endtask

  task automatic t_rx();
    sync_clear();
    dir_rx = 1'b1; xfer_active = 1'b1;
    cfg_wr(16'h8300);
    for (int i = 0; i < 3; i++) push(16'h0100 + 16'(i));
    chk("R5 equal level no dreq", rx_dreq, 0);
    push(16'h0103);
    chk("R5 above level dreq", rx_dreq, 1);
    chk("R9 rx dir no tx dreq", tx_dreq, 0);
    pop_chk("R5 pop", 16'h0100);
    chk("R5 dreq drops", rx_dreq, 0);
    cfg_wr(16'h0300);
    chk("R6 below clears", rx_rdy_clr, 1);
    chk("R6 no set", rx_rdy_set, 0);
    push(16'h0104);
    chk("R6 set pulse", rx_rdy_set, 1);
    chk("R6 no dreq", rx_dreq, 0);
    chk("R9 no tx set", tx_rdy_set, 0);
    @(negedge clk);
    chk("R12 one cycle", {rx_rdy_set, rx_rdy_clr}, 0);
  endtask

  task automatic t_tx();
    sync_clear();
    dir_rx = 1'b0; xfer_active = 1'b1;
    cfg_wr(16'h0084);
    chk("R7 below level dreq", tx_dreq, 1);
    chk("R11 dma write clears", {tx_rdy_set, tx_rdy_clr}, 2'b01);
    for (int i = 0; i < 3; i++) push(16'h0200 + 16'(i));
    chk("R7 count 3 dreq", tx_dreq, 1);
    push(16'h0203);
    chk("R7 equal level no dreq", tx_dreq, 0);
    chk("R9 tx dir no rx dreq", rx_dreq, 0);
    cfg_wr(16'h0008);
    chk("R8 set pulse", tx_rdy_set, 1);
    chk("R8 no dreq", tx_dreq, 0);
    chk("R9 no rx set", rx_rdy_set, 0);
    cfg_wr(16'h0088);
    chk("R11 clear on dma enable", {tx_rdy_set, tx_rdy_clr}, 2'b01);
    chk("R7 dreq with dma", tx_dreq, 1);
  endtask

  task automatic t_idle();
    sync_clear();
    dir_rx = 1'b0; xfer_active = 1'b0;
    cfg_wr(16'h0004);
    chk("R10 both clear", {rx_rdy_set, rx_rdy_clr, tx_rdy_set, tx_rdy_clr}, 4'b0101);
    cfg_wr(16'h0084);
    chk("R10 no dreq idle", tx_dreq, 0);
    xfer_active = 1'b1;
    @(negedge clk);
    chk("R14 level follows active", tx_dreq, 1);
    chk("R12 no strobe without event", {tx_rdy_set, tx_rdy_clr}, 0);
  endtask

  task automatic t_clear();
    push(16'h1111);
    push(16'h2222);
    clr = 1'b1; wr_en = 1'b1; wr_data = 16'h9999;
    @(negedge clk);
    clr = 1'b0; wr_en = 1'b0;
    chk("R13 fill zero", fill_level, 0);
    chk("R13 empty", empty, 1);
    push(16'h3333);
    pop_chk("R13 restart", 16'h3333);
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; xfer_active = 1'b0; dir_rx = 1'b0;
    cfg_we = 1'b0; cfg_wdata = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_wrap();
    t_overflow();
    t_empty_read();
    t_rx();
    t_tx();
    t_idle();
    t_clear();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule